// File: doc/BRIEF.md
# Prioritised Interrupt Level Evaluator

This block merges pending software interrupt requests and external interrupt lines into one priority level and one summary bit vector. Both kinds of request share a single level space. A software request on bit `i` maps to level `i - SW_LO + 1`. An external line `j` maps to the level equal to its summary bit position, `EXT_LO + j`. When several requests are active, the last active bit in a fixed scan order sets the level. The scan covers all software bits in ascending order and then all external bits in ascending order, so any external line outranks every software request.

The pending level is compared with a current priority-level register. A trap request is raised only when the pending level is nonzero and strictly above that register. The request is held together with a frozen snapshot of the level and summary until an accept pulse arrives. On acceptance, the snapshot is loaded into an interrupt summary register and an interrupt-ID register. The software request register and the priority register are written through plain write-enable ports, which strip the bits each register does not implement. The current values of both registers are visible on output ports.

Top module: `irq_level_eval`

## Requirements
- R1: The software request register keeps only bits 18 down to 4 of a write (mask 0x7fff0). All other written bits read back as zero on `sw_q` after the write.
- R2: A set software request bit `i` (4 ≤ i ≤ 18) sets summary bit `i` and gives level `i - 3`.
- R3: External line `ext_req[j]` sets summary bit `20 + j` and gives level `20 + j`.
- R4: With several requests active, the level comes from the highest set external line. If no external line is set, it comes from the highest set software bit. The summary is the OR of all active request bits.
- R5: `trap_req` rises one clock edge after the registered inputs give a nonzero level strictly greater than `ipl_q`. An equal or lower level, or a level of zero, raises no trap.
- R6: While `trap_req` is high, a `trap_ack` at an edge loads `isr_q` with `trap_sum` and `intid_q` with `trap_lvl`, and drops `trap_req` at that same edge.
- R7: The priority-level register keeps only bits 4:0 of a write. `ipl_q` reads back the written value ANDed with 0x1f.
- R8: While a trap request waits for acceptance, `trap_lvl` and `trap_sum` hold their values, and changes on the request inputs are not sampled.
- R9: After reset, `trap_req`, `isr_q`, `intid_q`, `sw_q` and `ipl_q` are all zero.
- R10: `trap_ack` while `trap_req` is low has no effect on `isr_q`, `intid_q` or `trap_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Write strobe for the software request register |
| sw_wr_data | input | 32 | Write data for the software request register |
| ipl_wr_en | input | 1 | Write strobe for the priority-level register |
| ipl_wr_data | input | 32 | Write data for the priority-level register |
| ext_req | input | 12 | External interrupt request lines |
| trap_ack | input | 1 | Accept pulse for a pending trap request |
| trap_req | output | 1 | Trap request, held until accepted |
| trap_lvl | output | 5 | Level of the pending trap request |
| trap_sum | output | 32 | Summary vector of the pending trap request |
| isr_q | output | 32 | Interrupt summary register |
| intid_q | output | 5 | Interrupt-ID register |
| sw_q | output | 32 | Software request register contents |
| ipl_q | output | 32 | Priority-level register contents |

## Verification
Two functions can meet in one cycle: accepting a held trap, and re-arbitrating the requests that are still active. The bench provokes this by acknowledging a trap in the same cycle as it raises the priority register to 31. It then judges that the summary and ID registers take the held snapshot, and that no second trap follows from the still-asserted inputs. A second collision comes from changing the inputs while a request is pending. Here the bench checks that the snapshot stays frozen across several cycles, and that the later acceptance loads the old values rather than the new ones.

// File: rtl/irq_level_pkg.sv
// Package: shared defaults and helpers for the interrupt level evaluator.
// Assumes levels fit in LVL_W bits and all request bits fit in the summary.
package irq_level_pkg;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_LVL_W  = 5;
    localparam int DEF_SW_LO  = 4;
    localparam int DEF_SW_HI  = 18;
    localparam int DEF_EXT_LO = 20;
    localparam int DEF_EXT_N  = 12;

    // Builds a contiguous bit mask covering bits lo..hi.
    function automatic logic [DEF_DATA_W-1:0] range_mask(input int lo, input int hi);
        logic [DEF_DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DEF_DATA_W; b++) begin
            if (b >= lo && b <= hi) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ile_masked_reg.sv
// Module: register written through a strobe; bits outside MASK stay zero.
// Assumes a single writer and synchronous active-low reset to zero.
module ile_masked_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    // Capture the masked write data on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data & MASK;
    end
endmodule

// File: rtl/ile_level_enc.sv
// Module: combinational encoder from software and external requests to
// a level and a summary vector. The scan runs over software bits and then
// over external bits, both ascending, and the last set bit wins.
// Assumes EXT_LO + EXT_N <= SUM_W and that levels fit in LVL_W bits.
module ile_level_enc #(
    parameter int SUM_W  = 32,
    parameter int LVL_W  = 5,
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_N  = 12
) (
    input  logic [SUM_W-1:0] sw_req,
    input  logic [EXT_N-1:0] ext_req,
    output logic [LVL_W-1:0] lvl,
    output logic [SUM_W-1:0] sum
);
    localparam int SW_N = SW_HI - SW_LO + 1;

    logic [SUM_W-1:0] sw_part;
    logic [SUM_W-1:0] ext_part;

    // Spread each external line onto its own summary position.
    genvar g;
    generate
        for (g = 0; g < SUM_W; g++) begin : g_ext_map
            if (g >= EXT_LO && g < EXT_LO + EXT_N) begin : g_hit
                assign ext_part[g] = ext_req[g - EXT_LO];
            end else begin : g_miss
                assign ext_part[g] = 1'b0;
            end
            if (g >= SW_LO && g <= SW_HI) begin : g_sw
                assign sw_part[g] = sw_req[g];
            end else begin : g_nosw
                assign sw_part[g] = 1'b0;
            end
        end
    endgenerate

    // Summary is the union of every active request bit.
    assign sum = sw_part | ext_part;

    // Priority scan: software ascending, then external ascending.
    always_comb begin
        lvl = '0;
        for (int i = 0; i < SW_N; i++) begin
            if (sw_part[SW_LO + i]) lvl = LVL_W'(i + 1);
        end
        for (int j = 0; j < EXT_N; j++) begin
            if (ext_part[EXT_LO + j]) lvl = LVL_W'(EXT_LO + j);
        end
    end

    // The low and high unused bits of sw_req are covered by sw_part's mask.
    logic unused_sw;
    assign unused_sw = ^(sw_req & ~sw_part);
endmodule

// File: rtl/ile_trap_hold.sv
// Module: compares the pending level to the priority register, holds a
// trap request with a frozen snapshot, and loads the summary and ID
// registers on acceptance. Assumes trap_ack is meaningful only while
// trap_req is high.
module ile_trap_hold #(
    parameter int DATA_W = 32,
    parameter int SUM_W  = 32,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [SUM_W-1:0]  sum,
    input  logic [DATA_W-1:0] ipl,
    input  logic              trap_ack,
    output logic              trap_req,
    output logic [LVL_W-1:0]  trap_lvl,
    output logic [SUM_W-1:0]  trap_sum,
    output logic [SUM_W-1:0]  isr_q,
    output logic [LVL_W-1:0]  intid_q
);
    logic take;

    // A trap is due only for a nonzero level strictly above the register.
    assign take = (lvl != '0) && (DATA_W'(lvl) > ipl);

    // Request/snapshot state and the registers loaded on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req <= 1'b0;
            trap_lvl <= '0;
            trap_sum <= '0;
            isr_q    <= '0;
            intid_q  <= '0;
        end else if (trap_req) begin
            if (trap_ack) begin
                trap_req <= 1'b0;
                isr_q    <= trap_sum;
                intid_q  <= trap_lvl;
            end
        end else if (take) begin
            trap_req <= 1'b1;
            trap_lvl <= lvl;
            trap_sum <= sum;
        end
    end
endmodule

// File: rtl/irq_level_eval.sv
// Module: top of the interrupt level evaluator. Holds the software request
// and priority registers, encodes the pending level, and manages the trap
// handshake. Assumes SUM_W == DATA_W so the summary fits a register.
module irq_level_eval
    import irq_level_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int LVL_W  = DEF_LVL_W,
    parameter int SW_LO  = DEF_SW_LO,
    parameter int SW_HI  = DEF_SW_HI,
    parameter int EXT_LO = DEF_EXT_LO,
    parameter int EXT_N  = DEF_EXT_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [DATA_W-1:0] sw_wr_data,
    input  logic              ipl_wr_en,
    input  logic [DATA_W-1:0] ipl_wr_data,
    input  logic [EXT_N-1:0]  ext_req,
    input  logic              trap_ack,
    output logic              trap_req,
    output logic [LVL_W-1:0]  trap_lvl,
    output logic [DATA_W-1:0] trap_sum,
    output logic [DATA_W-1:0] isr_q,
    output logic [LVL_W-1:0]  intid_q,
    output logic [DATA_W-1:0] sw_q,
    output logic [DATA_W-1:0] ipl_q
);
    localparam logic [DATA_W-1:0] SW_MASK  = DATA_W'(range_mask(SW_LO, SW_HI));
    localparam logic [DATA_W-1:0] IPL_MASK = DATA_W'(range_mask(0, LVL_W - 1));

    logic [LVL_W-1:0]  enc_lvl;
    logic [DATA_W-1:0] enc_sum;

    ile_masked_reg #(.W(DATA_W), .MASK(SW_MASK)) u_sw_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(sw_wr_en), .wr_data(sw_wr_data), .q(sw_q)
    );

    ile_masked_reg #(.W(DATA_W), .MASK(IPL_MASK)) u_ipl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(ipl_wr_en), .wr_data(ipl_wr_data), .q(ipl_q)
    );

    ile_level_enc #(
        .SUM_W(DATA_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
        .EXT_LO(EXT_LO), .EXT_N(EXT_N)
    ) u_enc (
        .sw_req(sw_q), .ext_req(ext_req), .lvl(enc_lvl), .sum(enc_sum)
    );

    ile_trap_hold #(.DATA_W(DATA_W), .SUM_W(DATA_W), .LVL_W(LVL_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .lvl(enc_lvl), .sum(enc_sum), .ipl(ipl_q),
        .trap_ack(trap_ack), .trap_req(trap_req), .trap_lvl(trap_lvl),
        .trap_sum(trap_sum), .isr_q(isr_q), .intid_q(intid_q)
    );
endmodule

// File: rtl/irq_level_eval_chk.sv
// Checker: temporal properties of the interrupt level evaluator, bound
// to the top module. Observes ports only.
module irq_level_eval_chk
    import irq_level_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int LVL_W  = DEF_LVL_W,
    parameter int SW_LO  = DEF_SW_LO,
    parameter int SW_HI  = DEF_SW_HI
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr_en,
    input logic [DATA_W-1:0] sw_wr_data,
    input logic              ipl_wr_en,
    input logic [DATA_W-1:0] ipl_wr_data,
    input logic              trap_ack,
    input logic              trap_req,
    input logic [LVL_W-1:0]  trap_lvl,
    input logic [DATA_W-1:0] trap_sum,
    input logic [DATA_W-1:0] isr_q,
    input logic [LVL_W-1:0]  intid_q,
    input logic [DATA_W-1:0] sw_q,
    input logic [DATA_W-1:0] ipl_q
);
    localparam logic [DATA_W-1:0] SW_MASK  = DATA_W'(range_mask(SW_LO, SW_HI));
    localparam logic [DATA_W-1:0] IPL_MASK = DATA_W'(range_mask(0, LVL_W - 1));

    a_r1_sw_mask: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> sw_q == ($past(sw_wr_data) & SW_MASK));

    a_r7_ipl_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_wr_en |=> ipl_q == ($past(ipl_wr_data) & IPL_MASK));

    a_r5_strict_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_req) |-> (trap_lvl != '0) && (DATA_W'(trap_lvl) > $past(ipl_q)));

    a_r6_accept_load: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_ack) |=> !trap_req && isr_q == $past(trap_sum)
                                   && intid_q == $past(trap_lvl));

    a_r8_hold_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> trap_req && $stable(trap_lvl) && $stable(trap_sum));

    a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> $stable(isr_q) && $stable(intid_q));
endmodule

bind irq_level_eval irq_level_eval_chk #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI)
) u_chk (.*);

// File: tb/irq_level_eval_tb.sv
// Scoreboard bench: driver tasks queue expected traps, a monitor accepts
// each trap and compares the snapshot and the loaded registers.
module irq_level_eval_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic        ipl_wr_en = 1'b0;
    logic [31:0] ipl_wr_data = '0;
    logic [11:0] ext_req = '0;
    logic        trap_ack = 1'b0;
    logic        trap_req;
    logic [4:0]  trap_lvl;
    logic [31:0] trap_sum;
    logic [31:0] isr_q;
    logic [4:0]  intid_q;
    logic [31:0] sw_q;
    logic [31:0] ipl_q;

    int errors = 0;
    int checks = 0;
    bit auto_ack = 1'b1;
    bit stray_ack = 1'b0;
    bit pend_chk = 1'b0;
    logic [4:0]  exp_lvl_q[$];
    logic [31:0] exp_sum_q[$];
    logic [4:0]  cur_lvl;
    logic [31:0] cur_sum;

    always #5 clk = ~clk;

    irq_level_eval u_dut (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data), .ext_req(ext_req),
        .trap_ack(trap_ack), .trap_req(trap_req), .trap_lvl(trap_lvl),
        .trap_sum(trap_sum), .isr_q(isr_q), .intid_q(intid_q), .sw_q(sw_q), .ipl_q(ipl_q)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: accept a trap, compare snapshot, then compare loaded registers.
    always @(negedge clk) begin
        if (pend_chk) begin
            trap_ack = 1'b0;
            pend_chk = 1'b0;
            chk(isr_q == cur_sum, "R6", "isr_q", isr_q, cur_sum);
            chk(intid_q == cur_lvl, "R6", "intid_q", 32'(intid_q), 32'(cur_lvl));
            chk(!trap_req, "R6", "trap_req after accept", 32'(trap_req), 32'd0);
        end else if (trap_req && auto_ack) begin
            if (exp_lvl_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected trap level", 32'(trap_lvl), 32'd0);
                cur_lvl = trap_lvl;
                cur_sum = trap_sum;
            end else begin
                cur_lvl = exp_lvl_q.pop_front();
                cur_sum = exp_sum_q.pop_front();
                chk(trap_lvl == cur_lvl, "R4", "trap_lvl", 32'(trap_lvl), 32'(cur_lvl));
                chk(trap_sum == cur_sum, "R4", "trap_sum", trap_sum, cur_sum);
            end
            trap_ack = 1'b1;
            pend_chk = 1'b1;
        end else begin
            trap_ack = stray_ack;
        end
    end

    task automatic wr_sw(input logic [31:0] d);
        @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = d;
        @(negedge clk); sw_wr_en = 1'b0;
    endtask

    task automatic wr_ipl(input logic [31:0] d);
        @(negedge clk); ipl_wr_en = 1'b1; ipl_wr_data = d;
        @(negedge clk); ipl_wr_en = 1'b0;
    endtask

    // Driver: queue expectation, open the priority window, close it at the trap.
    task automatic fire(input string req, input logic [31:0] ipl_val,
                        input logic [4:0] lvl, input logic [31:0] sum);
        bit got = 1'b0;
        exp_lvl_q.push_back(lvl);
        exp_sum_q.push_back(sum);
        wr_ipl(ipl_val);
        for (int k = 0; k < 6 && !got; k++) begin
            @(negedge clk);
            if (trap_req) begin
                got = 1'b1;
                ipl_wr_en = 1'b1;
                ipl_wr_data = 32'd31;
            end
        end
        @(negedge clk); ipl_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (!got) begin
            chk(1'b0, req, "trap not raised", 32'd0, 32'd1);
            void'(exp_lvl_q.pop_front());
            void'(exp_sum_q.pop_front());
        end
    endtask

    task automatic no_trap(input string req, input string what);
        bit seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (trap_req) seen = 1'b1;
        end
        chk(!seen, req, what, 32'(seen), 32'd0);
    endtask

    task automatic clear_all();
        ext_req = '0;
        wr_sw(32'd0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        chk(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(trap_req == 1'b0 && isr_q == 0 && intid_q == 0, "R9", "reset outputs",
            {isr_q[15:0], 11'd0, intid_q} | 32'(trap_req), 32'd0);
        chk(sw_q == 0 && ipl_q == 0, "R9", "reset registers", sw_q | ipl_q, 32'd0);
        rst_n = 1'b1;
        wr_ipl(32'd31);

        // R1: software register keeps bits 18..4 only; R2/R4 highest bit 18 -> level 15
        wr_sw(32'hFFFF_FFFF);
        @(negedge clk);
        chk(sw_q == 32'h0007_FFF0, "R1", "sw_q masked", sw_q, 32'h0007_FFF0);
        fire("R2", 32'd0, 5'd15, 32'h0007_FFF0);
        clear_all();

        // R2: lowest software bit 4 -> level 1
        wr_sw(32'h0000_0010);
        fire("R2", 32'd0, 5'd1, 32'h0000_0010);

        // R5: equal level raises nothing
        wr_ipl(32'd1);
        no_trap("R5", "equal level trapped");
        wr_ipl(32'd31);
        clear_all();

        // R4: two software bits, ascending scan picks bit 12 -> level 9
        wr_sw(32'h0000_1020);
        fire("R4", 32'd0, 5'd9, 32'h0000_1020);
        clear_all();

        // R3/R4: external line 0 outranks software bit 9
        wr_sw(32'h0000_0200);
        ext_req = 12'h001;
        fire("R3", 32'd5, 5'd20, 32'h0010_0200);
        clear_all();

        // R3/R4: external lines 3 and 11 -> level 31
        ext_req = 12'h808;
        fire("R3", 32'd30, 5'd31, 32'h8080_0000);
        clear_all();

        // R5: no requests at all means no trap even at priority 0
        wr_ipl(32'd0);
        no_trap("R5", "zero level trapped");
        wr_ipl(32'd31);

        // R7: priority register keeps bits 4:0
        wr_ipl(32'hFFFF_FFE3);
        @(negedge clk);
        chk(ipl_q == 32'd3, "R7", "ipl_q masked", ipl_q, 32'd3);
        wr_ipl(32'd31);
        wr_sw(32'h0000_0040);
        wr_ipl(32'hFFFF_FFE3);
        no_trap("R7", "level 3 trapped at priority 3");
        wr_ipl(32'd31);
        clear_all();
        wr_sw(32'h0000_0080);
        fire("R7", 32'hFFFF_FFE3, 5'd4, 32'h0000_0080);
        clear_all();

        // R8: snapshot frozen while request waits
        auto_ack = 1'b0;
        ext_req = 12'h004;
        wr_ipl(32'd0);
        repeat (2) @(negedge clk);
        chk(trap_req && trap_lvl == 5'd22, "R8", "held trap level", 32'(trap_lvl), 32'd22);
        ext_req = 12'h800;
        wr_sw(32'h0004_0000);
        repeat (3) @(negedge clk);
        chk(trap_lvl == 5'd22 && trap_sum == 32'h0040_0000, "R8", "snapshot changed",
            trap_sum, 32'h0040_0000);
        wr_ipl(32'd31);
        exp_lvl_q.push_back(5'd22);
        exp_sum_q.push_back(32'h0040_0000);
        auto_ack = 1'b1;
        repeat (4) @(negedge clk);
        chk(exp_lvl_q.size() == 0, "R8", "held trap not accepted",
            32'(exp_lvl_q.size()), 32'd0);
        clear_all();

        // R10: stray accept has no effect
        stray_ack = 1'b1;
        repeat (3) @(negedge clk);
        stray_ack = 1'b0;
        @(negedge clk);
        chk(isr_q == 32'h0040_0000, "R10", "isr_q after stray accept", isr_q, 32'h0040_0000);
        chk(intid_q == 5'd22 && !trap_req, "R10", "intid_q after stray accept",
            32'(intid_q), 32'd22);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule